// File: doc/BRIEF.md
# Masked SIMD Lane Controller

This block applies a per-lane 32-bit operation across a vector of 4, 8 or 16 lanes (128, 256 or 512 bits) inside a 512-bit register. A request carries the first source vector and a second operand that comes from one of three places: a register vector, a memory vector, or a single 32-bit memory element copied into every lane. A per-lane write mask decides which lanes are computed. Each lane that is not computed either keeps the previous destination value (merge mode) or is written with zero (zero mode). Destination bits above the selected vector length are always cleared.

The same broadcast bit has two jobs. With a memory source it copies the scalar into every lane. With a register source at 512 bits it switches the rounding mode from the global field to the field embedded in the request. The per-lane arithmetic is a stub: a wrapping 32-bit add with a carry flag and a zero-result flag. Flags from active lanes are ORed together.

A small controller sequences each request. ST_IDLE accepts a start pulse and captures all operands, moving to ST_EXEC (transition "accept"). ST_EXEC forms the result and registers it, moving to ST_DONE (transition "commit"). ST_DONE raises done for one cycle and returns to ST_IDLE (transition "release"). A start pulse in ST_EXEC or ST_DONE is ignored.

Top module: `simd_lane_ctrl`

## Requirements
- R1: `vl_sel` encodes the vector length as 00 = 4 lanes (128 bits), 01 = 8 lanes (256 bits), 10 = 16 lanes (512 bits). Lane j is bits 32j+31..32j of every vector. All `dst` bits at and above the selected length are zero.
- R2: A lane inside the length is active when its `wmask` bit is set or when `no_mask` is 1. An active lane is written with (src1 lane + second operand lane) mod 2^32.
- R3: A lane inside the length that is not active takes the `old_dst` lane when `zero_mode` is 0 and takes zero when `zero_mode` is 1.
- R4: The second operand is the `src2_reg` lane when `src2_is_mem` is 0, whatever `bcast` is. It is the `src2_mem` lane when `src2_is_mem` is 1 and `bcast` is 0. It is `mem_scalar` for every lane when both are 1.
- R5: `rnd_mode` is `rc_embedded` when `vl_sel` is 10, `bcast` is 1 and `src2_is_mem` is 0. In every other case it is `rc_global`.
- R6: `vl_sel` = 11 is reserved. It gives `dst` all zero, `flags` zero and `vl_err` = 1. Any valid encoding gives `vl_err` = 0.
- R7: `flags[0]` is the OR of the add carry-outs of the active lanes. `flags[1]` is the OR over active lanes of "lane result is zero". Lanes that are masked off or outside the length contribute nothing.
- R8: `done` is high for exactly one cycle, on the second rising edge after the edge that accepts `start` in idle, and `dst`, `flags`, `rnd_mode` and `vl_err` update on that same edge. Inputs are captured at acceptance. A `start` seen while busy is ignored.
- R9: After reset, `done`, `dst`, `flags`, `rnd_mode` and `vl_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request pulse, accepted in idle |
| vl_sel | input | 2 | Vector length encoding |
| src1 | input | 512 | First source vector |
| src2_reg | input | 512 | Second source, register form |
| src2_mem | input | 512 | Second source, memory form |
| mem_scalar | input | 32 | Single memory element for broadcast |
| src2_is_mem | input | 1 | 1 selects a memory second source |
| bcast | input | 1 | Broadcast / embedded-rounding enable |
| wmask | input | 16 | Per-lane write mask |
| no_mask | input | 1 | 1 makes every lane in length active |
| zero_mode | input | 1 | 1 zeroes masked lanes, 0 merges |
| old_dst | input | 512 | Previous destination contents |
| rc_embedded | input | 2 | Rounding field carried in the request |
| rc_global | input | 2 | Global rounding field |
| done | output | 1 | One-cycle result strobe |
| dst | output | 512 | New destination vector |
| flags | output | 2 | OR of active-lane flags |
| rnd_mode | output | 2 | Rounding mode chosen for the request |
| vl_err | output | 1 | Reserved length encoding seen |

## Verification
If the controller state is wrong, the fault shows first on `done`: it arrives early, late, twice, or not at all, and the bench compares `done` at every sampled cycle of each request. If the captured operands or the lane window are wrong, the fault shows in the same cycle as `done`. It appears as a wrong lane in `dst`, non-zero bits above the length, a wrong flag bit, or the wrong rounding field. The mask patterns (all ones, all zeros, alternating, single bit) are run in both modes at all three lengths, so a lane-select error cannot hide behind a uniform mask.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_e;

    localparam logic [1:0] VL_128  = 2'b00;
    localparam logic [1:0] VL_256  = 2'b01;
    localparam logic [1:0] VL_512  = 2'b10;
    localparam logic [1:0] VL_RSVD = 2'b11;

    // number of active-length lanes for a length code (0 for the reserved code)
    function automatic int lanes_for(input logic [1:0] sel);
        int n;
        unique case (sel)
            VL_128:  n = 4;
            VL_256:  n = 8;
            VL_512:  n = 16;
            default: n = 0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lane_operand_mux.sv
module lane_operand_mux #(
    parameter int LANE_W = 32,
    parameter int LANES  = 16,
    localparam int VEC_W = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  reg_vec,
    input  logic [VEC_W-1:0]  mem_vec,
    input  logic [LANE_W-1:0] scalar,
    input  logic              is_mem,
    input  logic              bcast,
    output logic [VEC_W-1:0]  opb
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign opb[j*LANE_W +: LANE_W] =
            !is_mem ? reg_vec[j*LANE_W +: LANE_W] :
            (bcast  ? scalar : mem_vec[j*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/lane_stub_alu.sv
module lane_stub_alu #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res,
    output logic              carry,
    output logic              is_zero
);

    always_comb begin
        {carry, res} = {1'b0, a} + {1'b0, b};
        is_zero      = (res == '0);
    end

endmodule

// File: rtl/lane_mask_merge.sv
module lane_mask_merge #(
    parameter int LANE_W = 32,
    parameter int LANES  = 16,
    parameter int FLAG_W = 2,
    localparam int VEC_W = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]        lane_res,
    input  logic [LANES*FLAG_W-1:0] lane_flags,
    input  logic [LANES-1:0]        in_window,
    input  logic [LANES-1:0]        active,
    input  logic                    zero_mode,
    input  logic [VEC_W-1:0]        old_vec,
    output logic [VEC_W-1:0]        out_vec,
    output logic [FLAG_W-1:0]       flag_or
);

    for (genvar j = 0; j < LANES; j++) begin : g_sel
        assign out_vec[j*LANE_W +: LANE_W] =
            !in_window[j] ? '0 :
            active[j]     ? lane_res[j*LANE_W +: LANE_W] :
            zero_mode     ? '0 : old_vec[j*LANE_W +: LANE_W];
    end

    always_comb begin
        flag_or = '0;
        for (int j = 0; j < LANES; j++) begin
            if (active[j]) flag_or = flag_or | lane_flags[j*FLAG_W +: FLAG_W];
        end
    end

endmodule

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
    import simd_lane_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int MAX_LANES = 16,
    parameter int FLAG_W    = 2,
    parameter int RC_W      = 2,
    localparam int VEC_W    = LANE_W * MAX_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           vl_sel,
    input  logic [VEC_W-1:0]     src1,
    input  logic [VEC_W-1:0]     src2_reg,
    input  logic [VEC_W-1:0]     src2_mem,
    input  logic [LANE_W-1:0]    mem_scalar,
    input  logic                 src2_is_mem,
    input  logic                 bcast,
    input  logic [MAX_LANES-1:0] wmask,
    input  logic                 no_mask,
    input  logic                 zero_mode,
    input  logic [VEC_W-1:0]     old_dst,
    input  logic [RC_W-1:0]      rc_embedded,
    input  logic [RC_W-1:0]      rc_global,
    output logic                 done,
    output logic [VEC_W-1:0]     dst,
    output logic [FLAG_W-1:0]    flags,
    output logic [RC_W-1:0]      rnd_mode,
    output logic                 vl_err
);

    ctrl_state_e state_q, state_d;

    // operands captured at acceptance
    logic [1:0]           cap_vl;
    logic [VEC_W-1:0]     cap_src1, cap_reg, cap_mem, cap_old;
    logic [LANE_W-1:0]    cap_scalar;
    logic                 cap_is_mem, cap_bcast, cap_nomask, cap_zero;
    logic [MAX_LANES-1:0] cap_mask;
    logic [RC_W-1:0]      cap_emb, cap_glob;

    logic                 accept;
    assign accept = (state_q == ST_IDLE) && start;

    // next-state logic: accept, commit, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vl <= '0; cap_src1 <= '0; cap_reg <= '0; cap_mem <= '0;
            cap_old <= '0; cap_scalar <= '0; cap_is_mem <= 1'b0;
            cap_bcast <= 1'b0; cap_nomask <= 1'b0; cap_zero <= 1'b0;
            cap_mask <= '0; cap_emb <= '0; cap_glob <= '0;
        end else if (accept) begin
            cap_vl <= vl_sel; cap_src1 <= src1; cap_reg <= src2_reg;
            cap_mem <= src2_mem; cap_old <= old_dst; cap_scalar <= mem_scalar;
            cap_is_mem <= src2_is_mem; cap_bcast <= bcast;
            cap_nomask <= no_mask; cap_zero <= zero_mode; cap_mask <= wmask;
            cap_emb <= rc_embedded; cap_glob <= rc_global;
        end
    end

    // lane window and activity
    logic [MAX_LANES-1:0] in_window, active;
    always_comb begin
        int n;
        n = lanes_for(cap_vl);
        for (int j = 0; j < MAX_LANES; j++) begin
            in_window[j] = (j < n);
            active[j]    = in_window[j] && (cap_mask[j] || cap_nomask);
        end
    end

    logic [VEC_W-1:0] opb;
    lane_operand_mux #(.LANE_W(LANE_W), .LANES(MAX_LANES)) u_opmux (
        .reg_vec (cap_reg),
        .mem_vec (cap_mem),
        .scalar  (cap_scalar),
        .is_mem  (cap_is_mem),
        .bcast   (cap_bcast),
        .opb     (opb)
    );

    logic [VEC_W-1:0]            lane_res;
    logic [MAX_LANES*FLAG_W-1:0] lane_flags;
    for (genvar j = 0; j < MAX_LANES; j++) begin : g_alu
        logic c, z;
        lane_stub_alu #(.LANE_W(LANE_W)) u_alu (
            .a       (cap_src1[j*LANE_W +: LANE_W]),
            .b       (opb[j*LANE_W +: LANE_W]),
            .res     (lane_res[j*LANE_W +: LANE_W]),
            .carry   (c),
            .is_zero (z)
        );
        assign lane_flags[j*FLAG_W]     = c;
        assign lane_flags[j*FLAG_W + 1] = z;
        if (FLAG_W > 2) begin : g_pad
            assign lane_flags[j*FLAG_W + 2 +: FLAG_W-2] = '0;
        end
    end

    logic [VEC_W-1:0]  merged;
    logic [FLAG_W-1:0] flag_or;
    lane_mask_merge #(.LANE_W(LANE_W), .LANES(MAX_LANES), .FLAG_W(FLAG_W)) u_merge (
        .lane_res   (lane_res),
        .lane_flags (lane_flags),
        .in_window  (in_window),
        .active     (active),
        .zero_mode  (cap_zero),
        .old_vec    (cap_old),
        .out_vec    (merged),
        .flag_or    (flag_or)
    );

    logic use_embedded;
    assign use_embedded = (cap_vl == VL_512) && cap_bcast && !cap_is_mem;

    // output register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0; dst <= '0; flags <= '0; rnd_mode <= '0; vl_err <= 1'b0;
        end else begin
            done <= (state_q == ST_EXEC);
            if (state_q == ST_EXEC) begin
                dst      <= merged;
                flags    <= flag_or;
                rnd_mode <= use_embedded ? cap_emb : cap_glob;
                vl_err   <= (cap_vl == VL_RSVD);
            end
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> ##1 done);
    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vl_err |-> (dst == '0 && flags == '0));
    // R1
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_vl == VL_128) |-> (dst[VEC_W-1:4*LANE_W] == '0));
    // R5
    rnd_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_vl != VL_512) |-> (rnd_mode == cap_glob));
    // R8
    stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(dst));

endmodule

// File: tb/simd_lane_ctrl_test.sv
module simd_lane_ctrl_test;

    logic clk = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    logic         rst_n, start, src2_is_mem, bcast, no_mask, zero_mode;
    logic [1:0]   vl_sel, rc_embedded, rc_global;
    logic [511:0] src1, src2_reg, src2_mem, old_dst;
    logic [31:0]  mem_scalar;
    logic [15:0]  wmask;
    logic         done, vl_err;
    logic [511:0] dst;
    logic [1:0]   flags, rnd_mode;

    simd_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_sel(vl_sel),
        .src1(src1), .src2_reg(src2_reg), .src2_mem(src2_mem),
        .mem_scalar(mem_scalar), .src2_is_mem(src2_is_mem), .bcast(bcast),
        .wmask(wmask), .no_mask(no_mask), .zero_mode(zero_mode),
        .old_dst(old_dst), .rc_embedded(rc_embedded), .rc_global(rc_global),
        .done(done), .dst(dst), .flags(flags), .rnd_mode(rnd_mode), .vl_err(vl_err)
    );

    int checks = 0;
    int errors = 0;

    logic [511:0] e_dst;
    logic [1:0]   e_flags, e_rnd;
    logic         e_err;

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference from the requirements
    task automatic model();
        int n;
        n = (vl_sel == 2'b11) ? 0 : (4 << vl_sel);
        e_dst = '0; e_flags = '0;
        e_err = (vl_sel == 2'b11);
        e_rnd = (vl_sel == 2'b10 && bcast && !src2_is_mem) ? rc_embedded : rc_global;
        for (int j = 0; j < 16; j++) begin
            longint unsigned a, b, s;
            if (j < n) begin
                if (wmask[j] || no_mask) begin
                    a = longint'(src1[j*32 +: 32]);
                    if (!src2_is_mem)  b = longint'(src2_reg[j*32 +: 32]);
                    else if (!bcast)   b = longint'(src2_mem[j*32 +: 32]);
                    else               b = longint'(mem_scalar);
                    s = a + b;
                    e_dst[j*32 +: 32] = s[31:0];
                    if (s >= 64'h1_0000_0000) e_flags[0] = 1'b1;
                    if (s[31:0] == 32'd0)     e_flags[1] = 1'b1;
                end else if (!zero_mode) begin
                    e_dst[j*32 +: 32] = old_dst[j*32 +: 32];
                end
            end
        end
    endtask

    task automatic fill();
        for (int j = 0; j < 16; j++) begin
            src1[j*32 +: 32]     = $urandom;
            src2_reg[j*32 +: 32] = $urandom;
            src2_mem[j*32 +: 32] = $urandom;
            old_dst[j*32 +: 32]  = $urandom;
        end
        mem_scalar = $urandom;
    endtask

    // one request; busy=1 re-pulses start with altered data while busy
    task automatic run_op(input logic [1:0] vl, input logic mem, input logic bc,
                          input logic [15:0] mask, input logic nm, input logic zm,
                          input logic busy);
        @(negedge clk);
        vl_sel = vl; src2_is_mem = mem; bcast = bc; wmask = mask;
        no_mask = nm; zero_mode = zm; rc_embedded = 2'b11; rc_global = 2'b01;
        model();
        start = 1'b1;
        @(negedge clk);
        chk("R8 done early", {511'd0, done}, 512'd0);
        if (busy) begin
            src1 = ~src1; wmask = ~wmask; vl_sel = 2'b11;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        chk("R8 done", {511'd0, done}, 512'd1);
        chk("R1/R2/R3/R4 dst", dst, e_dst);
        chk("R7 flags", {510'd0, flags}, {510'd0, e_flags});
        chk("R5 rnd_mode", {510'd0, rnd_mode}, {510'd0, e_rnd});
        chk("R6 vl_err", {511'd0, vl_err}, {511'd0, e_err});
        @(negedge clk);
        chk("R8 single done", {511'd0, done}, 512'd0);
        chk("R8 hold dst", dst, e_dst);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pat;
        rst_n = 1'b0; start = 1'b0; vl_sel = '0; src2_is_mem = 0; bcast = 0;
        wmask = '0; no_mask = 0; zero_mode = 0; rc_embedded = '0; rc_global = '0;
        src1 = '0; src2_reg = '0; src2_mem = '0; old_dst = '0; mem_scalar = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 done", {511'd0, done}, 512'd0);
        chk("R9 dst", dst, 512'd0);
        chk("R9 flags", {510'd0, flags}, 512'd0);
        chk("R9 rnd_mode", {510'd0, rnd_mode}, 512'd0);
        chk("R9 vl_err", {511'd0, vl_err}, 512'd0);
        rst_n = 1'b1;

        // R1 R2 R3: every mask class, both modes, all lengths
        for (int v = 0; v < 3; v++) begin
            for (int z = 0; z < 2; z++) begin
                for (int p = 0; p < 4; p++) begin
                    case (p)
                        0: pat = 16'hFFFF;
                        1: pat = 16'h0000;
                        2: pat = 16'h5555;
                        default: pat = 16'h0001 << (2 + v);
                    endcase
                    fill();
                    run_op(v[1:0], 1'b0, 1'b0, pat, 1'b0, z[0], 1'b0);
                end
            end
        end
        // R2 no_mask overrides an all-zero mask
        fill(); run_op(2'b10, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0);
        // R4 memory vector, memory broadcast
        fill(); run_op(2'b01, 1'b1, 1'b0, 16'h00F3, 1'b0, 1'b0, 1'b0);
        fill(); run_op(2'b10, 1'b1, 1'b1, 16'hAAAA, 1'b0, 1'b0, 1'b0);
        // R5 embedded rounding at 512 register, global elsewhere
        fill(); run_op(2'b10, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        fill(); run_op(2'b01, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        // R6 reserved length
        fill(); run_op(2'b11, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0);
        // R7 carry and zero from an active lane, hidden when lane masked
        fill(); src1[31:0] = 32'hFFFF_FFFF; src2_reg[31:0] = 32'd1;
        run_op(2'b00, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b1, 1'b0);
        fill(); src1[31:0] = 32'hFFFF_FFFF; src2_reg[31:0] = 32'd1;
        src1[63:32] = 32'd0; src2_reg[63:32] = 32'd5;
        run_op(2'b00, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b0, 1'b0);
        // R8 start while busy is ignored
        fill(); run_op(2'b01, 1'b0, 1'b0, 16'h0F0F, 1'b0, 1'b1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule